// File: doc/BRIEF.md
# Keyed XOR Window Flow Hash

This block turns a 336-bit flow tuple and a 32-bit key into a 16-bit hash. The key is widened into a 351-bit selector. The tuple is widened into a 366-bit ring image by adding a 15-bit guard band at each end. For every set selector bit, the 16-bit window of the ring image that starts at the same position is XORed into the result. AND stands in for multiplication and XOR stands in for addition. The engine is sequential. It evaluates `BITS_PER_CYCLE` selector positions per clock, so one design parameter trades area against latency, and the result does not change with that choice.

A client presents the key and the tuple, then raises `start_i` for one cycle. Both operands are captured at that edge. `busy_o` stays high while the windows are folded in. `done_o` then pulses for one cycle, and `hash_o` takes the new result at the same edge. The result stays on `hash_o` until the next computation completes.

Top module: `flow_hash_engine`

## Requirements
- R1: While reset is held and after it is released, `busy_o` and `done_o` are 0 and `hash_o` is 0x0000.
- R2: The selector bit at position i (i = 0..350) equals `key_i[(i+1) mod 32]`. This is the same as repeating the key eleven times and discarding the lowest bit of the 352-bit word.
- R3: The ring image is 366 bits wide. Bits [14:0] hold tuple bits [335:321]. Bits [350:15] hold tuple bits [335:0]. Bits [365:351] hold tuple bits [14:0].
- R4: The result starts at zero. For each i from 0 to 350 whose selector bit is 1, ring image bits [i+15:i] are XORed into it.
- R5: A start accepted while idle raises `busy_o` after the capturing edge. `done_o` is high for exactly one cycle, at ceil(351/`BITS_PER_CYCLE`) cycles after that edge. This is 351 cycles for one position per clock and 88 cycles for four.
- R6: Any `BITS_PER_CYCLE` from 1 to 351 gives the same result as the one-position form. Positions that fall past 350 in the last step contribute nothing.
- R7: The key and the tuple are captured on the start edge. Changes on `key_i` and `stream_i` during a computation do not affect its result.
- R8: `start_i` asserted while `busy_o` is high is ignored. It neither restarts nor shortens the running computation.
- R9: `hash_o` changes only on the edge that raises `done_o`. It holds the previous result through a later computation until that computation completes.
- R10: An all-zero key or an all-zero tuple yields 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request, sampled when idle |
| key_i | input | 32 | Hash key |
| stream_i | input | 336 | Flow tuple |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hash_o | output | 16 | Last completed result |

## Verification
Single-bit keys (bit 0 alone, bit 31 alone) are paired with random tuples. They show whether the selector is built with the correct one-bit offset and the correct wrap, because a mistake moves which ten or eleven windows are used. Tuples with only bit 0 or only bit 335 set, under an all-ones key, isolate each guard band and the order of the ring image. Zero operands and random operands are run on a one-position instance and a four-position instance at the same time. Since 4 does not divide 351, a mismatch between the two exposes incorrect handling of the tail step. Mid-run input changes and a second start pulse show whether the operands are really captured and whether the running job is protected from a restart.

// File: rtl/flow_hash_pkg.sv
package flow_hash_pkg;
  localparam int FH_KEY_W    = 32;
  localparam int FH_STREAM_W = 336;
  localparam int FH_HASH_W   = 16;
  localparam int FH_KEY_REPL = 11;

  function automatic int fh_steps(input int positions, input int lanes);
    return (positions + lanes - 1) / lanes;
  endfunction
endpackage

// File: rtl/fh_key_expand.sv
module fh_key_expand #(
  parameter int KEY_W    = 32,
  parameter int KEY_REPL = 11,
  localparam int REP_W   = KEY_W * KEY_REPL,
  localparam int EXT_W   = REP_W - 1
) (
  input  logic [KEY_W-1:0] key_i,
  output logic [EXT_W-1:0] ext_key_o
);
  logic [REP_W-1:0] rep;

  for (genvar r = 0; r < KEY_REPL; r++) begin : g_rep
    assign rep[r*KEY_W +: KEY_W] = key_i;
  end

  // lowest replicated bit is discarded
  assign ext_key_o = rep[REP_W-1:1];
endmodule

// File: rtl/fh_stream_extend.sv
module fh_stream_extend #(
  parameter int STREAM_W = 336,
  parameter int GUARD_W  = 15,
  localparam int EXT_W   = STREAM_W + 2 * GUARD_W
) (
  input  logic [STREAM_W-1:0] stream_i,
  output logic [EXT_W-1:0]    ext_stream_o
);
  assign ext_stream_o = {stream_i[GUARD_W-1:0], stream_i,
                         stream_i[STREAM_W-1 -: GUARD_W]};
endmodule

// File: rtl/fh_window_fold.sv
module fh_window_fold #(
  parameter int HASH_W = 16,
  parameter int LANES  = 1,
  localparam int SRC_W = LANES + HASH_W - 1
) (
  input  logic [LANES-1:0]  sel_i,
  input  logic [SRC_W-1:0]  src_i,
  output logic [HASH_W-1:0] fold_o
);
  logic [HASH_W-1:0] part  [LANES];
  logic [HASH_W-1:0] chain [LANES+1];

  assign chain[0] = '0;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign part[l]    = sel_i[l] ? src_i[l +: HASH_W] : '0;
    assign chain[l+1] = chain[l] ^ part[l];
  end

  assign fold_o = chain[LANES];
endmodule

// File: rtl/fh_step_ctrl.sv
module fh_step_ctrl #(
  parameter int STEPS  = 351,
  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign last_o = busy_q && (cnt_q == CNT_W'(STEPS - 1));
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (last_o) busy_q <= 1'b0;
        else        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/flow_hash_engine.sv
module flow_hash_engine
  import flow_hash_pkg::*;
#(
  parameter int KEY_W          = FH_KEY_W,
  parameter int STREAM_W       = FH_STREAM_W,
  parameter int HASH_W         = FH_HASH_W,
  parameter int KEY_REPL       = FH_KEY_REPL,
  parameter int BITS_PER_CYCLE = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [KEY_W-1:0]    key_i,
  input  logic [STREAM_W-1:0] stream_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [HASH_W-1:0]   hash_o
);
  localparam int EXT_KEY_W    = KEY_W * KEY_REPL - 1;
  localparam int GUARD_W      = HASH_W - 1;
  localparam int EXT_STREAM_W = STREAM_W + 2 * GUARD_W;
  localparam int STEPS        = fh_steps(EXT_KEY_W, BITS_PER_CYCLE);
  localparam int SRC_W        = BITS_PER_CYCLE + HASH_W - 1;

  logic [EXT_KEY_W-1:0]    ext_key;
  logic [EXT_STREAM_W-1:0] ext_stream;
  logic [EXT_KEY_W-1:0]    sel_q;
  logic [EXT_STREAM_W-1:0] ring_q;
  logic [HASH_W-1:0]       acc_q;
  logic [HASH_W-1:0]       hash_q;
  logic [HASH_W-1:0]       fold;
  logic [HASH_W-1:0]       acc_nxt;
  logic                    load, step, last;

  fh_key_expand #(.KEY_W(KEY_W), .KEY_REPL(KEY_REPL)) u_key (
    .key_i     (key_i),
    .ext_key_o (ext_key)
  );

  fh_stream_extend #(.STREAM_W(STREAM_W), .GUARD_W(GUARD_W)) u_str (
    .stream_i     (stream_i),
    .ext_stream_o (ext_stream)
  );

  // shifted-out selector fills with zeros, so tail lanes add nothing
  fh_window_fold #(.HASH_W(HASH_W), .LANES(BITS_PER_CYCLE)) u_fold (
    .sel_i  (sel_q[BITS_PER_CYCLE-1:0]),
    .src_i  (ring_q[SRC_W-1:0]),
    .fold_o (fold)
  );

  fh_step_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  assign acc_nxt = acc_q ^ fold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      ring_q <= '0;
      acc_q  <= '0;
      hash_q <= '0;
    end else if (load) begin
      sel_q  <= ext_key;
      ring_q <= ext_stream;
      acc_q  <= '0;
    end else if (step) begin
      sel_q  <= sel_q >> BITS_PER_CYCLE;
      ring_q <= ring_q >> BITS_PER_CYCLE;
      acc_q  <= acc_nxt;
      if (last) hash_q <= acc_nxt;
    end
  end

  assign hash_o = hash_q;
endmodule

// File: rtl/fh_checker.sv
module fh_checker #(
  parameter int EXT_KEY_W      = 351,
  parameter int BITS_PER_CYCLE = 1,
  parameter int HASH_W         = 16,
  localparam int STEPS         = (EXT_KEY_W + BITS_PER_CYCLE - 1) / BITS_PER_CYCLE
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [HASH_W-1:0] hash_o
);
  int unsigned lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 lat_q <= 0;
    else if (start_i && !busy_o) lat_q <= 0;
    else if (busy_o)             lat_q <= lat_q + 1;
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  // R5
  launch_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R5 R8
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == STEPS));

  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hash_o != $past(hash_o)) |-> done_o);
endmodule

bind flow_hash_engine fh_checker #(
  .EXT_KEY_W      (EXT_KEY_W),
  .BITS_PER_CYCLE (BITS_PER_CYCLE),
  .HASH_W         (HASH_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .hash_o  (hash_o)
);

// File: tb/flow_hash_engine_tb.sv
module flow_hash_engine_tb;
  localparam int STEPS_S = 351;
  localparam int STEPS_P = 88;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  key = '0;
  logic [335:0] stream = '0;
  logic         busy_s, done_s, busy_p, done_p;
  logic [15:0]  hash_s, hash_p;
  logic [15:0]  prev_s = '0, prev_p = '0;
  int           n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  flow_hash_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .key_i(key),
    .stream_i(stream), .busy_o(busy_s), .done_o(done_s), .hash_o(hash_s)
  );

  flow_hash_engine #(.BITS_PER_CYCLE(4)) u_dut_par (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .key_i(key),
    .stream_i(stream), .busy_o(busy_p), .done_o(done_p), .hash_o(hash_p)
  );

  function automatic logic [15:0] ref_hash(input logic [31:0] k, input logic [335:0] s);
    logic [15:0] h = '0;
    for (int i = 0; i < 351; i++) begin
      if (k[(i + 1) % 32]) begin
        for (int b = 0; b < 16; b++) begin
          int m = i + b;
          logic v = (m < 15) ? s[321 + m] : ((m < 351) ? s[m - 15] : s[m - 351]);
          h[b] = h[b] ^ v;
        end
      end
    end
    return h;
  endfunction

  function automatic logic [335:0] rnd_stream();
    logic [335:0] s = '0;
    for (int w = 0; w < 11; w++) s = {s[303:0], $urandom()};
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // mode 0: plain, 1: inputs change mid-run (R7), 2: second start mid-run (R8)
  task automatic run_job(input logic [31:0] k, input logic [335:0] s, input int mode, input string tag);
    logic [15:0] exp = ref_hash(k, s);
    int lat_s = -1, lat_p = -1, np_s = 0, np_p = 0;
    bit hold_ok = 1'b1;
    @(negedge clk);
    key = k; stream = s; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int c = 1; c <= STEPS_S + 5; c++) begin
      if (mode == 1 && c == 10) begin key = ~k; stream = ~s; end
      if (mode == 2 && c == 50) begin key = ~k; stream = rnd_stream(); start = 1'b1; end
      if (mode == 2 && c == 51) start = 1'b0;
      @(posedge clk); #1;
      if (done_s) begin np_s++; if (lat_s < 0) lat_s = c; end
      if (done_p) begin np_p++; if (lat_p < 0) lat_p = c; end
      if (lat_s < 0 && hash_s != prev_s) hold_ok = 1'b0;
      if (lat_p < 0 && hash_p != prev_p) hold_ok = 1'b0;
    end
    chk(lat_s == STEPS_S && np_s == 1, {"R5 serial latency ", tag}, lat_s, STEPS_S);
    chk(lat_p == STEPS_P && np_p == 1, {"R5 parallel latency ", tag}, lat_p, STEPS_P);
    chk(hash_s == exp, {tag, " serial hash"}, hash_s, exp);
    chk(hash_p == exp, {"R6 parallel hash ", tag}, hash_p, exp);
    chk(hold_ok && !busy_s && !busy_p, {"R9 hold ", tag}, {31'd0, hold_ok}, 1);
    prev_s = exp;
    prev_p = exp;
  endtask

  task automatic t_reset();
    chk(!busy_s && !done_s && hash_s == 0, "R1 serial reset", {15'd0, busy_s, done_s, hash_s}, 0);
    chk(!busy_p && !done_p && hash_p == 0, "R1 parallel reset", {15'd0, busy_p, done_p, hash_p}, 0);
  endtask

  task automatic t_zero();
    run_job(32'h0, rnd_stream(), 0, "R10 zero key");
    chk(hash_s == 16'h0, "R10 zero key value", hash_s, 0);
    run_job(32'hDEADBEEF, '0, 0, "R10 zero tuple");
    chk(hash_s == 16'h0, "R10 zero tuple value", hash_s, 0);
  endtask

  task automatic t_key_bits();
    run_job(32'h0000_0001, rnd_stream(), 0, "R2 key bit0");
    run_job(32'h8000_0000, rnd_stream(), 0, "R2 key bit31");
  endtask

  task automatic t_guard();
    run_job(32'hFFFF_FFFF, 336'h1, 0, "R3 tuple bit0");
    run_job(32'hFFFF_FFFF, 336'h1 << 335, 0, "R3 tuple bit335");
    run_job(32'h1234_5678, 336'h1 << 330, 0, "R3 tuple bit330");
  endtask

  task automatic t_random();
    for (int n = 0; n < 4; n++) run_job($urandom(), rnd_stream(), 0, "R4 random");
    run_job(32'hFFFF_FFFF, {336{1'b1}}, 0, "R4 all ones");
  endtask

  task automatic t_capture();
    run_job(32'hA5C3_0F96, rnd_stream(), 1, "R7 inputs change");
  endtask

  task automatic t_restart();
    run_job(32'h0BAD_F00D, rnd_stream(), 2, "R8 start while busy");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_zero();
    t_key_bits();
    t_guard();
    t_random();
    t_capture();
    t_restart();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule